// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver with Start Qualification

This block recovers asynchronous serial bytes from a line sampled sixteen times per bit. A one-cycle enable marks each oversampling tick. The bit rate itself comes from outside the block. While searching, the receiver waits for a low sample that follows at least three high samples. It treats that low sample as tick 1 of a possible start bit and then looks at the line again at ticks 3, 5 and 7. A short glitch is thrown away without trace. A real start bit is accepted and the frame is received.

Each of the eight data bits and the stop bit is judged by majority over ticks 8, 9 and 10 of its bit time. Because of this, a perceived bit edge that sits a few ticks away from the real one still yields the right byte. After the stop bit the block presents the byte together with a one-cycle valid strobe, a noise indication and a framing-error indication. It then returns to searching, and it needs fresh high samples before it will accept another start.

Top module: `os_uart_rx`

## Requirements
- R1: While reset is asserted and right after it is released, `byteOut` is 0 and `byteValid`, `noiseSeen` and `frameErr` are all low.
- R2: A low sample begins a start candidate only when at least three consecutive high samples came directly before it. A line that is low from reset, or low after only two highs, never produces a byte.
- R3: The receiver's state advances only in cycles where `rtTick` is high. Line activity while `rtTick` is low has no effect on the outputs.
- R4: The candidate is accepted only when at least two of the samples at ticks 3, 5 and 7 are low. Otherwise the candidate is dropped with no `byteValid`, and the search begins again.
- R5: A dropped candidate does not change `noiseSeen`. The next clean frame reports `noiseSeen` low.
- R6: If a start bit is accepted while one of its three verification samples is high, `noiseSeen` is high for that frame.
- R7: Each data bit takes the majority of its samples at ticks 8, 9 and 10. Bits arrive least significant first, so the first data bit received lands in `byteOut[0]`.
- R8: If the three samples of any data bit do not all agree, `noiseSeen` is high for the frame, and the majority value is still stored.
- R9: If the stop-bit majority is low, `frameErr` is high. The byte is still presented, with `byteValid`.
- R10: `byteValid` is high for exactly one clock, in the cycle right after the tick that carries the stop bit's tick-10 sample. `byteOut`, `noiseSeen` and `frameErr` change only at that moment and hold until the next frame ends.
- R11: After a frame ends, a new start is accepted only after three new high samples. A line that stays low after the stop bit yields no further bytes.
- R12: When the perceived start edge comes four ticks before the real one, the byte is still recovered correctly and `noiseSeen` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rtTick | input | 1 | Oversampling tick enable, one per sixteenth of a bit |
| rxLine | input | 1 | Serial input line, already synchronous to clk |
| byteOut | output | 8 | Last received byte |
| byteValid | output | 1 | One-cycle strobe when a frame completes |
| noiseSeen | output | 1 | Noise observed inside the last accepted frame |
| frameErr | output | 1 | Stop bit of the last frame sampled low |

## Verification
Every result appears together at the `byteValid` strobe. That strobe rises in the clock right after the tick carrying the stop bit's tick-10 sample, and `byteOut`, `noiseSeen` and `frameErr` settle in that same clock. The bench notes the cycle in which it drives that tick and expects the strobe to be seen exactly one cycle later. It reads the held byte and flags only after a few idle ticks have passed. Inputs change on the falling clock edge and outputs are sampled there too, so no check depends on the order of processes at the active edge. For rejected candidates and for tick-gated activity, the bench counts strobes over the whole window of the stimulus and expects that count to be zero.

// File: rtl/os_uart_rx_pkg.sv
package os_uart_rx_pkg;

  typedef enum logic [1:0] {
    ST_SEARCH,
    ST_START,
    ST_DATA,
    ST_STOP
  } rxState_e;

  // strobes from control to datapath, valid only in tick cycles
  typedef struct packed {
    logic clrFrame;     // new candidate: clear per-frame noise
    logic shiftVote;    // store current line sample into vote history
    logic commitStart;  // start accepted: fold verification disagreement into noise
    logic commitBit;    // store majority as next data bit
    logic commitStop;   // stop judged: publish byte and flags
  } rxCtrl_t;

endpackage

// File: rtl/os_uart_rx_ctrl.sv
module os_uart_rx_ctrl
  import os_uart_rx_pkg::*;
#(
  parameter int RT_PER_BIT = 16,
  parameter int DATA_BITS  = 8,
  parameter int IDLE_RUN   = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    rtTick,
  input  logic    rxLine,
  input  logic    voteLow,
  output rxCtrl_t ctrl
);

  localparam int RT_W  = $clog2(RT_PER_BIT + 1);
  localparam int BIT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam int HI_W  = $clog2(IDLE_RUN + 1);
  localparam int MID   = RT_PER_BIT / 2;

  localparam logic [RT_W-1:0]  RT_LAST = RT_W'(RT_PER_BIT);
  localparam logic [RT_W-1:0]  RT_ONE  = RT_W'(1);
  localparam logic [RT_W-1:0]  VER_A   = RT_W'(MID - 5);
  localparam logic [RT_W-1:0]  VER_B   = RT_W'(MID - 3);
  localparam logic [RT_W-1:0]  VER_C   = RT_W'(MID - 1);
  localparam logic [RT_W-1:0]  SMP_A   = RT_W'(MID);
  localparam logic [RT_W-1:0]  SMP_B   = RT_W'(MID + 1);
  localparam logic [RT_W-1:0]  SMP_C   = RT_W'(MID + 2);
  localparam logic [BIT_W-1:0] BIT_END = BIT_W'(DATA_BITS - 1);
  localparam logic [HI_W-1:0]  HI_FULL = HI_W'(IDLE_RUN);

  rxState_e         state, stateNxt;
  logic [RT_W-1:0]  rtCnt, rtNxt, curRt;
  logic [BIT_W-1:0] bitIdx, bitNxt;
  logic [HI_W-1:0]  hiCnt, hiNxt;

  assign curRt = rtCnt + RT_ONE;

  always_comb begin
    ctrl     = '0;
    stateNxt = state;
    rtNxt    = rtCnt;
    bitNxt   = bitIdx;
    hiNxt    = hiCnt;
    if (rtTick) begin
      if (state == ST_SEARCH) begin
        if (rxLine) begin
          if (hiCnt != HI_FULL) hiNxt = hiCnt + 1'b1;
        end else begin
          hiNxt = '0;
          if (hiCnt == HI_FULL) begin
            stateNxt      = ST_START;
            rtNxt         = RT_ONE;
            ctrl.clrFrame = 1'b1;
          end
        end
      end else if (rtCnt == RT_LAST) begin
        rtNxt = RT_ONE;
        if (state == ST_START) begin
          stateNxt = ST_DATA;
          bitNxt   = '0;
        end else if (state == ST_DATA) begin
          if (bitIdx == BIT_END) stateNxt = ST_STOP;
          else bitNxt = bitIdx + 1'b1;
        end
      end else begin
        rtNxt = curRt;
        if (state == ST_START) begin
          if (curRt == VER_A || curRt == VER_B) ctrl.shiftVote = 1'b1;
          if (curRt == VER_C) begin
            if (voteLow) begin
              ctrl.commitStart = 1'b1;
            end else begin
              stateNxt = ST_SEARCH;
              hiNxt    = '0;
            end
          end
        end else begin
          if (curRt == SMP_A || curRt == SMP_B) ctrl.shiftVote = 1'b1;
          if (curRt == SMP_C) begin
            if (state == ST_DATA) begin
              ctrl.commitBit = 1'b1;
            end else begin
              ctrl.commitStop = 1'b1;
              stateNxt        = ST_SEARCH;
              hiNxt           = '0;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_SEARCH;
      rtCnt  <= '0;
      bitIdx <= '0;
      hiCnt  <= '0;
    end else begin
      state  <= stateNxt;
      rtCnt  <= rtNxt;
      bitIdx <= bitNxt;
      hiCnt  <= hiNxt;
    end
  end

  // a candidate is only opened from a full idle run and a low sample
  assert_idle_run_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && $past(state) == ST_SEARCH)
      |-> ($past(hiCnt) == HI_FULL && !$past(rxLine) && $past(rtTick)));

  // nothing moves without a tick
  assert_tick_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rtTick) |-> ($stable(state) && $stable(rtCnt) && $stable(hiCnt)));

  // the tick position stays inside one bit time while a frame is open
  assert_rt_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_SEARCH) |-> (rtCnt >= RT_ONE && rtCnt <= RT_LAST));

  // after the stop decision the idle run must be rebuilt from zero
  assert_rearm_R11: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.commitStop |=> (state == ST_SEARCH && hiCnt == '0));

endmodule

// File: rtl/os_uart_rx_dp.sv
module os_uart_rx_dp
  import os_uart_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxLine,
  input  rxCtrl_t              ctrl,
  output logic                 voteLow,
  output logic [DATA_BITS-1:0] byteOut,
  output logic                 byteValid,
  output logic                 noiseSeen,
  output logic                 frameErr
);

  logic [1:0]           votes;
  logic [DATA_BITS-1:0] shiftReg;
  logic                 noiseAcc;
  logic                 voteHigh, voteSplit;

  // majority and agreement over the two stored samples and the live one
  assign voteHigh  = (votes[1] & votes[0]) | (votes[1] & rxLine) | (votes[0] & rxLine);
  assign voteSplit = !((votes[1] == votes[0]) && (votes[0] == rxLine));
  assign voteLow   = !voteHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      votes     <= '0;
      shiftReg  <= '0;
      noiseAcc  <= 1'b0;
      byteOut   <= '0;
      byteValid <= 1'b0;
      noiseSeen <= 1'b0;
      frameErr  <= 1'b0;
    end else begin
      byteValid <= 1'b0;
      if (ctrl.shiftVote)   votes <= {votes[0], rxLine};
      if (ctrl.clrFrame)    noiseAcc <= 1'b0;
      if (ctrl.commitStart) noiseAcc <= noiseAcc | voteSplit;
      if (ctrl.commitBit) begin
        shiftReg <= {voteHigh, shiftReg[DATA_BITS-1:1]};
        noiseAcc <= noiseAcc | voteSplit;
      end
      if (ctrl.commitStop) begin
        byteOut   <= shiftReg;
        noiseSeen <= noiseAcc | voteSplit;
        frameErr  <= voteLow;
        byteValid <= 1'b1;
      end
    end
  end

  assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);

  assert_valid_source_R10: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> $past(ctrl.commitStop));

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.commitStop |=> ($stable(byteOut) && $stable(noiseSeen) && $stable(frameErr)));

endmodule

// File: rtl/os_uart_rx.sv
module os_uart_rx
  import os_uart_rx_pkg::*;
#(
  parameter int RT_PER_BIT = 16,
  parameter int DATA_BITS  = 8,
  parameter int IDLE_RUN   = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rtTick,
  input  logic                 rxLine,
  output logic [DATA_BITS-1:0] byteOut,
  output logic                 byteValid,
  output logic                 noiseSeen,
  output logic                 frameErr
);

  rxCtrl_t ctrl;
  logic    voteLow;

  os_uart_rx_ctrl #(
    .RT_PER_BIT(RT_PER_BIT),
    .DATA_BITS (DATA_BITS),
    .IDLE_RUN  (IDLE_RUN)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .rtTick (rtTick),
    .rxLine (rxLine),
    .voteLow(voteLow),
    .ctrl   (ctrl)
  );

  os_uart_rx_dp #(
    .DATA_BITS(DATA_BITS)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .rxLine   (rxLine),
    .ctrl     (ctrl),
    .voteLow  (voteLow),
    .byteOut  (byteOut),
    .byteValid(byteValid),
    .noiseSeen(noiseSeen),
    .frameErr (frameErr)
  );

endmodule

// File: tb/os_uart_rx_tb_top.sv
`timescale 1ns/1ps
module os_uart_rx_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic       rtTick;
  logic       rxLine;
  logic [7:0] byteOut;
  logic       byteValid, noiseSeen, frameErr;

  int checks   = 0;
  int fails    = 0;
  int cyc      = 0;
  int stopCyc  = 0;
  int validCnt = 0;
  int validCyc = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  os_uart_rx dut_i (
    .clk(clk), .rstN(rstN), .rtTick(rtTick), .rxLine(rxLine),
    .byteOut(byteOut), .byteValid(byteValid), .noiseSeen(noiseSeen), .frameErr(frameErr)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (byteValid) begin
      validCnt = validCnt + 1;
      validCyc = cyc;
    end
  end

  // {data[14:7], glitch[6:3] (0-7 data bit, 8 start tick 3, 15 none), stopHigh, expNoise, expFerr}
  localparam logic [14:0] VEC [6] = '{
    {8'hA5, 4'hF, 1'b1, 1'b0, 1'b0},
    {8'h00, 4'hF, 1'b1, 1'b0, 1'b0},
    {8'hFF, 4'h3, 1'b1, 1'b1, 1'b0},
    {8'h5A, 4'h8, 1'b1, 1'b1, 1'b0},
    {8'h81, 4'hF, 1'b0, 1'b0, 1'b1},
    {8'h3C, 4'h7, 1'b0, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic v, input bit mark);
    @(negedge clk);
    rtTick = 1'b1;
    rxLine = v;
    if (mark) stopCyc = cyc;
    @(negedge clk);
    rtTick = 1'b0;
  endtask

  task automatic ticks(input logic v, input int n);
    for (int i = 0; i < n; i++) tick(v, 0);
  endtask

  task automatic sendBody(input logic [7:0] d, input logic [3:0] g, input logic stopHigh);
    for (int t = 1; t <= 16; t++) tick((g == 4'h8 && t == 3) ? 1'b1 : 1'b0, 0);
    for (int b = 0; b < 8; b++)
      for (int t = 1; t <= 16; t++) tick(d[b] ^ (g == 4'(b) && t == 9), 0);
    for (int t = 1; t <= 16; t++) tick(stopHigh, t == 10);
  endtask

  initial begin
    rstN = 1'b0; rtTick = 1'b0; rxLine = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 byteOut in reset", 32'(byteOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 byteOut", 32'(byteOut), 0);
    chk("R1 byteValid", 32'(byteValid), 0);
    chk("R1 noiseSeen", 32'(noiseSeen), 0);
    chk("R1 frameErr", 32'(frameErr), 0);

    // R2: low from reset, then only two highs before a long low
    validCnt = 0;
    ticks(1'b0, 30);
    ticks(1'b1, 2);
    ticks(1'b0, 40);
    chk("R2 no byte without idle run", 32'(validCnt), 0);

    // R3: full frame shape on the line with the tick held low
    validCnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); rxLine = 1'b1;
    end
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); rxLine = (i % 37 < 11) ? 1'b0 : 1'b1;
    end
    chk("R3 no byte without ticks", 32'(validCnt), 0);
    chk("R3 outputs untouched", 32'({byteOut, noiseSeen, frameErr}), 0);

    // vector table: R6 R7 R8 R9 R10
    for (int v = 0; v < 6; v++) begin
      validCnt = 0;
      ticks(1'b1, 4);
      sendBody(VEC[v][14:7], VEC[v][6:3], VEC[v][2]);
      ticks(1'b1, 4);
      chk("R10 one strobe per frame", 32'(validCnt), 1);
      chk("R10 strobe one cycle after stop sample", 32'(validCyc), 32'(stopCyc + 1));
      chk("R7 byte value lsb first", 32'(byteOut), 32'(VEC[v][14:7]));
      chk("R8 R6 noise flag", 32'(noiseSeen), 32'(VEC[v][1]));
      chk("R9 framing flag", 32'(frameErr), 32'(VEC[v][0]));
    end

    // R4/R5: two glitches rejected, flags held from last frame
    validCnt = 0;
    ticks(1'b1, 4); ticks(1'b0, 1); ticks(1'b1, 15);
    ticks(1'b0, 3); ticks(1'b1, 20);
    chk("R4 rejected candidates give no byte", 32'(validCnt), 0);
    chk("R5 noise held across rejection", 32'(noiseSeen), 1);
    chk("R4 byte held across rejection", 32'(byteOut), 32'h3C);
    sendBody(8'hC3, 4'hF, 1'b1);
    ticks(1'b1, 4);
    chk("R5 clean frame after glitch", 32'(noiseSeen), 0);
    chk("R5 byte after glitch", 32'(byteOut), 32'hC3);
    chk("R5 one strobe", 32'(validCnt), 1);

    // R11: framing error then line stays low
    validCnt = 0;
    ticks(1'b1, 4);
    sendBody(8'h42, 4'hF, 1'b0);
    ticks(1'b0, 40);
    chk("R11 no restart on held low", 32'(validCnt), 1);
    chk("R11 frame error reported", 32'(frameErr), 1);

    // R12: perceived edge four ticks early
    validCnt = 0;
    ticks(1'b1, 4); ticks(1'b0, 1); ticks(1'b1, 3);
    sendBody(8'h96, 4'hF, 1'b1);
    ticks(1'b1, 6);
    chk("R12 one strobe", 32'(validCnt), 1);
    chk("R12 byte recovered", 32'(byteOut), 32'h96);
    chk("R12 noise flagged", 32'(noiseSeen), 1);
    chk("R12 no framing error", 32'(frameErr), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule